// File: doc/BRIEF.md
# Status-Reporting I2C Bus Master

This block is a byte-oriented I2C master run by a processor through three registers: a control register, a data register and a status register that software only reads. Software asks for a START, loads an address byte or a data byte, and chooses whether to acknowledge received bytes. After each bus event the controller raises an event flag and posts a one-byte status code that names the event. While that flag is set, the controller keeps SCL low, so the transfer stalls for as long as software takes to respond. Clearing the flag lets the transfer continue.

Both master directions are covered. These are START and repeated START, the address byte with its direction bit, data bytes in either direction, the acknowledge bit, STOP, and the loss of arbitration to another master. A divider sets the SCL rate. Its three rate bits pick a quarter-bit time of `BASE_DIV << rate` clock cycles. The bus pins are open drain: an `_oe` output high pulls the line low.

Control register bits: [7] enable, [6] start request, [5] stop request, [4] event flag (hardware sets it; software can only clear it, by writing 0), [3] acknowledge-on-receive, [2:0] rate select.

Top module: `i2c_stat_master`

## Requirements
- R1: After reset, status reads F8h, the control and data registers read 00h, and neither bus line is pulled.
- R2: With enable set, the event flag clear and the bus free, a start request produces a START condition. The flag then rises with status 08h, and hardware clears the start-request bit.
- R3: While another master holds the bus (a START has been seen with no STOP after it), a start request waits. Nothing is driven and the flag stays clear until a STOP is seen; only then is the START issued.
- R4: While the event flag is set and the bus is owned, SCL is held low and status and bus outputs stay frozen until software writes the flag to 0. Writing 1 to the flag never sets it.
- R5: After the controller sends an address byte whose bit 0 is 0 (write), status is 18h when the slave acknowledged it and 20h when it did not.
- R6: A data byte is sent MSB first. Status is 28h when the slave acknowledged it and 30h when it did not.
- R7: A START issued while the controller already owns the bus (repeated START) posts 10h.
- R8: After the controller sends an address byte whose bit 0 is 1 (read), status is 40h when the slave acknowledged it and 48h when it did not. An acknowledged read address switches the controller to receiving.
- R9: In receive mode each byte lands in the data register. The controller drives SDA low in the acknowledge slot when bit 3 of the control register is set (status 50h), and leaves SDA released when it is clear (status 58h).
- R10: If the controller reads SDA low while sending a 1 in an address or data bit, it posts 38h, sets the flag and releases both lines.
- R11: A stop request, with the flag cleared, produces a STOP. Both lines are then released, the stop request bit is cleared, the flag stays clear and status returns to F8h.
- R12: The SCL period within a byte is `4 * (BASE_DIV << rate)` clock cycles.
- R13: With enable clear, a start request is ignored and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 8 | Register write value |
| ctrl_q | output | 8 | Control register contents |
| data_q | output | 8 | Data register contents (last received byte) |
| status_q | output | 8 | Current status code |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
On every cycle, the bound assertions check the stall contract: while the flag is set the bus is frozen with SCL low, and after a lost arbitration both lines are released. They also check that a STOP leaves a clean idle state, that a disabled controller drives nothing, that the start request clears on the START report, and that only legal status codes appear. The bench's scenarios are the only place where the choice between codes is shown, since that choice depends on what the slave answered (18h/20h, 28h/30h, 40h/48h). The same goes for MSB-first data order, the byte received under ACK and under NACK, the deferral behind a foreign bus owner, and the SCL period at two rate settings.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [7:0] ST_START    = 8'h08;
  localparam logic [7:0] ST_RSTART   = 8'h10;
  localparam logic [7:0] ST_AW_ACK   = 8'h18;
  localparam logic [7:0] ST_AW_NACK  = 8'h20;
  localparam logic [7:0] ST_DW_ACK   = 8'h28;
  localparam logic [7:0] ST_DW_NACK  = 8'h30;
  localparam logic [7:0] ST_ARB_LOST = 8'h38;
  localparam logic [7:0] ST_AR_ACK   = 8'h40;
  localparam logic [7:0] ST_AR_NACK  = 8'h48;
  localparam logic [7:0] ST_DR_ACK   = 8'h50;
  localparam logic [7:0] ST_DR_NACK  = 8'h58;
  localparam logic [7:0] ST_IDLE     = 8'hF8;

  localparam int B_EN  = 7;
  localparam int B_STA = 6;
  localparam int B_STO = 5;
  localparam int B_FLG = 4;
  localparam int B_AA  = 3;

  typedef enum logic [2:0] {
    M_IDLE, M_START, M_HOLD, M_TX, M_RACK, M_RX, M_WACK, M_STOP
  } mstate_t;
endpackage

// File: rtl/i2cm_rate.sv
module i2cm_rate #(
  parameter int BASE_DIV = 4,
  parameter int RATE_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              qtick
);
  localparam int MAXQ = BASE_DIV << ((1 << RATE_W) - 1);
  localparam int CW   = $clog2(MAXQ + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = (CW'(BASE_DIV) << rate) - CW'(1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      qtick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt   <= '0;
      qtick <= 1'b1;
    end else begin
      cnt   <= cnt + CW'(1);
      qtick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic busy
);
  logic [SYNC-1:0] scl_sy, sda_sy;
  logic scl_s, scl_p, sda_p;

  assign scl_s = scl_sy[SYNC-1];
  assign sda_s = sda_sy[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      busy   <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
      if (scl_s && scl_p && sda_p && !sda_s)      busy <= 1'b1;
      else if (scl_s && scl_p && !sda_p && sda_s) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_stat_master.sv
module i2c_stat_master
  import i2cm_pkg::*;
#(
  parameter int BASE_DIV = 4,
  parameter int RATE_W   = 3,
  parameter int SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  output logic [7:0] data_q,
  output logic [7:0] status_q,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  mstate_t    st;
  logic [1:0] ph;
  logic [2:0] bc;
  logic [7:0] sh;
  logic       owned, is_addr, dir_rd, rx_mode, ackv;
  logic       qtick, sda_s, busy;
  logic [7:0] ack_code;

  i2cm_rate #(.BASE_DIV(BASE_DIV), .RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst(rst), .run(ctrl_q[B_EN]),
    .rate(ctrl_q[RATE_W-1:0]), .qtick(qtick)
  );

  i2cm_busmon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .busy(busy)
  );

  always_comb begin
    if (is_addr && dir_rd)  ack_code = ackv ? ST_AR_ACK : ST_AR_NACK;
    else if (is_addr)       ack_code = ackv ? ST_AW_ACK : ST_AW_NACK;
    else                    ack_code = ackv ? ST_DW_ACK : ST_DW_NACK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;  data_q <= '0;  status_q <= ST_IDLE;
      st <= M_IDLE;  ph <= '0;  bc <= '0;  sh <= '0;
      owned <= 1'b0; is_addr <= 1'b0; dir_rd <= 1'b0;
      rx_mode <= 1'b0; ackv <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (wr_en && !wr_sel)
        ctrl_q <= {wr_data[7:5], ctrl_q[B_FLG] & wr_data[B_FLG], wr_data[3:0]};
      if (wr_en && wr_sel) data_q <= wr_data;

      if (!ctrl_q[B_EN]) begin
        st <= M_IDLE; ph <= '0; owned <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (st)
          M_IDLE: begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            if (qtick && ctrl_q[B_STA] && !ctrl_q[B_FLG] && !busy) begin
              st <= M_START; ph <= '0;
            end
          end
          M_HOLD: if (qtick && !ctrl_q[B_FLG]) begin
            ph <= '0;
            bc <= '0;
            if (ctrl_q[B_STO])      st <= M_STOP;
            else if (ctrl_q[B_STA]) st <= M_START;
            else if (rx_mode)       st <= M_RX;
            else begin
              st <= M_TX; sh <= data_q;
              if (is_addr) dir_rd <= data_q[0];
            end
          end
          M_START: if (qtick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin
                scl_oe <= 1'b1;
                status_q <= owned ? ST_RSTART : ST_START;
                ctrl_q[B_FLG] <= 1'b1;
                ctrl_q[B_STA] <= 1'b0;
                owned <= 1'b1; is_addr <= 1'b1; rx_mode <= 1'b0;
                st <= M_HOLD;
              end
            endcase
          end
          M_TX: if (qtick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe <= !sh[7];
              2'd1: scl_oe <= 1'b0;
              2'd2: if (sh[7] && !sda_s) begin
                scl_oe <= 1'b0; sda_oe <= 1'b0;
                status_q <= ST_ARB_LOST;
                ctrl_q[B_FLG] <= 1'b1;
                owned <= 1'b0;
                st <= M_IDLE;
              end
              default: begin
                scl_oe <= 1'b1;
                sh <= {sh[6:0], 1'b0};
                bc <= bc + 3'd1;
                if (bc == 3'd7) st <= M_RACK;
              end
            endcase
          end
          M_RACK: if (qtick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: ackv <= !sda_s;
              default: begin
                scl_oe <= 1'b1;
                status_q <= ack_code;
                ctrl_q[B_FLG] <= 1'b1;
                if (is_addr && dir_rd && ackv) rx_mode <= 1'b1;
                is_addr <= 1'b0;
                st <= M_HOLD;
              end
            endcase
          end
          M_RX: if (qtick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sh <= {sh[6:0], sda_s};
              default: begin
                scl_oe <= 1'b1;
                bc <= bc + 3'd1;
                if (bc == 3'd7) st <= M_WACK;
              end
            endcase
          end
          M_WACK: if (qtick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: begin sda_oe <= ctrl_q[B_AA]; ackv <= ctrl_q[B_AA]; end
              2'd1: scl_oe <= 1'b0;
              2'd2: ;
              default: begin
                scl_oe <= 1'b1;
                data_q <= sh;
                status_q <= ackv ? ST_DR_ACK : ST_DR_NACK;
                ctrl_q[B_FLG] <= 1'b1;
                st <= M_HOLD;
              end
            endcase
          end
          M_STOP: if (qtick) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin
                status_q <= ST_IDLE;
                ctrl_q[B_STO] <= 1'b0;
                owned <= 1'b0;
                st <= M_IDLE;
              end
            endcase
          end
          default: st <= M_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] ctrl_q,
  input logic [7:0] status_q,
  input logic       scl_oe,
  input logic       sda_oe
);
  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[7] && $past(ctrl_q[7]) && ctrl_q[4] && status_q != 8'h38 |-> scl_oe); // R4

  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[7] && $past(ctrl_q[7]) && ctrl_q[4] && $past(ctrl_q[4])
    |-> $stable(status_q) && $stable(scl_oe) && $stable(sda_oe)); // R4

  AST_START_REPORT: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[4]) && (status_q == 8'h08 || status_q == 8'h10)
    |-> !ctrl_q[6] && scl_oe); // R2

  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[4] && status_q == 8'h38 |-> !scl_oe && !sda_oe); // R10

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    status_q == 8'hF8 && $past(status_q) != 8'hF8
    |-> !ctrl_q[5] && !ctrl_q[4] && !scl_oe && !sda_oe); // R11

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[7] && !$past(ctrl_q[7]) |-> !scl_oe && !sda_oe); // R13

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    status_q inside {8'h08, 8'h10, 8'h18, 8'h20, 8'h28, 8'h30, 8'h38,
                     8'h40, 8'h48, 8'h50, 8'h58, 8'hF8}); // R5
endmodule

bind i2c_stat_master i2cm_checker u_chk (
  .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .status_q(status_q),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_stat_master_bench.sv
`timescale 1ns/1ps
module i2c_stat_master_bench;
  localparam int BASE_DIV = 4;
  localparam logic [6:0] SLV_ADDR = 7'h50;
  localparam logic [7:0] EN = 8'h80, STA = 8'h40, STO = 8'h20, FLG = 8'h10, AA = 8'h08;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_q, data_q, status_q;
  logic scl_oe, sda_oe;
  logic ext_sda_low = 1'b0, s_drive = 1'b0;
  logic scl_w, sda_w;

  assign scl_w = !scl_oe;
  assign sda_w = !(sda_oe || s_drive || ext_sda_low);

  always #2.5 clk = ~clk;

  i2c_stat_master #(.BASE_DIV(BASE_DIV)) u_i2c_stat_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .data_q(data_q), .status_q(status_q),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard of expected status codes, popped on each flag rise
  logic [7:0] exp_q[$];
  string      req_q[$];
  logic       prev_flag = 1'b0;

  task automatic expect_code(input logic [7:0] code, input string req);
    exp_q.push_back(code);
    req_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (!rst && ctrl_q[4] && !prev_flag) begin
      if (exp_q.size() == 0) check(1'b0, "R4", "unexpected event", status_q, 8'h00);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(status_q == e, r, "status code", status_q, e);
      end
    end
    prev_flag = rst ? 1'b0 : ctrl_q[4];
  end

  // behavioural slave
  bit p_scl = 1, p_sda = 1, s_act = 0, s_addr = 0, s_tx = 0, s_dead = 0;
  bit in_ack = 0, s_rd = 0, s_match = 0, m_ack = 0, slave_ack = 1;
  int bc = 0;
  logic [7:0] s_sh = '0, s_txb = '0;
  logic [7:0] s_txq[$];
  logic [7:0] rxlog[$];

  always @(negedge clk) begin
    if (p_scl && scl_w && p_sda && !sda_w) begin
      s_act = 1; s_addr = 1; s_tx = 0; s_dead = 0; bc = 0; in_ack = 0; s_drive = 1'b0;
    end else if (p_scl && scl_w && !p_sda && sda_w) begin
      s_act = 0; s_drive = 1'b0;
    end else if (s_act && !s_dead) begin
      if (!p_scl && scl_w) begin
        if (!in_ack && bc < 8) begin
          if (!s_tx) s_sh = {s_sh[6:0], sda_w};
          bc++;
        end else if (in_ack && s_tx) m_ack = !sda_w;
      end else if (p_scl && !scl_w) begin
        if (!in_ack && bc == 8) begin
          in_ack = 1;
          if (s_tx) s_drive = 1'b0;
          else if (s_addr) begin
            s_rd = s_sh[0];
            s_match = (s_sh[7:1] == SLV_ADDR) && slave_ack;
            s_drive = s_match;
          end else begin
            rxlog.push_back(s_sh);
            s_drive = slave_ack;
          end
        end else if (in_ack) begin
          in_ack = 0; bc = 0; s_drive = 1'b0;
          if (s_addr) begin
            s_addr = 0;
            if (!s_match) s_dead = 1;
            else if (s_rd) s_tx = 1;
          end else if (s_tx && !m_ack) begin
            s_tx = 0; s_dead = 1;
          end
          if (s_tx && !s_dead) begin
            s_txb = (s_txq.size() > 0) ? s_txq.pop_front() : 8'hFF;
            s_drive = !s_txb[7];
          end
        end else if (s_tx && bc < 8) s_drive = !s_txb[7-bc];
      end
    end
    p_scl = scl_w;
    p_sda = sda_w;
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int i;
    for (i = 0; i < 20000 && !ctrl_q[4]; i++) @(negedge clk);
    if (!ctrl_q[4]) check(1'b0, req, "event flag timeout", 0, 1);
    @(negedge clk);
  endtask

  task automatic do_stop(input logic [7:0] extra);
    int i;
    wr(1'b0, EN | STO | extra);
    for (i = 0; i < 20000 && status_q != 8'hF8; i++) @(negedge clk);
    @(negedge clk);
    check(status_q == 8'hF8, "R11", "status after STOP", status_q, 8'hF8);
    check(ctrl_q[5] == 1'b0 && ctrl_q[4] == 1'b0, "R11", "stop/flag bits", ctrl_q, EN | extra);
    check(scl_w && sda_w, "R11", "lines released", {scl_w, sda_w}, 2'b11);
  endtask

  task automatic measure(input int exp, input string req);
    int t = 0, first = -1, second = -1;
    logic prev = scl_oe;
    while (second < 0 && t < 20000) begin
      @(negedge clk);
      t++;
      if (prev && !scl_oe) begin
        if (first < 0) first = t; else second = t;
      end
      prev = scl_oe;
    end
    check(second - first == exp, req, "SCL period", second - first, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(status_q == 8'hF8, "R1", "reset status", status_q, 8'hF8);
    check(ctrl_q == 8'h00 && data_q == 8'h00, "R1", "reset registers", {ctrl_q, data_q}, 0);
    check(!scl_oe && !sda_oe, "R1", "reset bus", {scl_oe, sda_oe}, 0);

    // R2 START, R4 stall, R5 write address, R6 data bytes, R12 rate 0
    expect_code(8'h08, "R2");
    wr(1'b0, EN | STA);
    wait_flag("R2");
    check(ctrl_q[6] == 1'b0, "R2", "start request cleared", ctrl_q[6], 0);
    repeat (300) @(negedge clk);
    check(!scl_w && ctrl_q[4] && status_q == 8'h08, "R4", "stalled with SCL low",
          {scl_w, ctrl_q[4], status_q}, {2'b01, 8'h08});
    expect_code(8'h18, "R5");
    wr(1'b1, 8'hA0); wr(1'b0, EN);
    wait_flag("R5");
    expect_code(8'h28, "R6");
    wr(1'b1, 8'h3C); wr(1'b0, EN);
    measure(4 * BASE_DIV, "R12");
    wait_flag("R6");
    check(rxlog.size() > 0 && rxlog[0] == 8'h3C, "R6", "slave byte MSB first",
          rxlog.size() > 0 ? rxlog[0] : 8'hXX, 8'h3C);
    if (rxlog.size() > 0) void'(rxlog.pop_front());
    slave_ack = 0;
    expect_code(8'h30, "R6");
    wr(1'b1, 8'h55); wr(1'b0, EN);
    wait_flag("R6");
    check(rxlog.size() > 0 && rxlog[0] == 8'h55, "R6", "slave byte 2",
          rxlog.size() > 0 ? rxlog[0] : 8'hXX, 8'h55);
    rxlog.delete();
    do_stop(8'h00);
    wr(1'b0, EN | FLG);
    repeat (20) @(negedge clk);
    check(!ctrl_q[4] && !scl_oe, "R4", "flag not settable by write", ctrl_q[4], 0);

    // R5 NACKed address, R7 repeated START, R8 read, R9 receive
    slave_ack = 1;
    s_txq.push_back(8'h9A); s_txq.push_back(8'h4B);
    expect_code(8'h08, "R2");
    wr(1'b0, EN | STA); wait_flag("R2");
    expect_code(8'h20, "R5");
    wr(1'b1, 8'h44); wr(1'b0, EN); wait_flag("R5");
    expect_code(8'h10, "R7");
    wr(1'b0, EN | STA); wait_flag("R7");
    expect_code(8'h40, "R8");
    wr(1'b1, 8'hA1); wr(1'b0, EN); wait_flag("R8");
    expect_code(8'h50, "R9");
    wr(1'b0, EN | AA); wait_flag("R9");
    check(data_q == 8'h9A, "R9", "received byte with ACK", data_q, 8'h9A);
    check(sda_oe == 1'b1, "R9", "ACK driven", sda_oe, 1);
    expect_code(8'h58, "R9");
    wr(1'b0, EN); wait_flag("R9");
    check(data_q == 8'h4B, "R9", "received byte with NACK", data_q, 8'h4B);
    check(sda_oe == 1'b0, "R9", "NACK released", sda_oe, 0);
    do_stop(8'h00);

    // R8 read address NACK
    slave_ack = 0;
    expect_code(8'h08, "R2");
    wr(1'b0, EN | STA); wait_flag("R2");
    expect_code(8'h48, "R8");
    wr(1'b1, 8'hA1); wr(1'b0, EN); wait_flag("R8");
    do_stop(8'h00);
    slave_ack = 1;

    // R10 arbitration loss
    expect_code(8'h08, "R2");
    wr(1'b0, EN | STA); wait_flag("R2");
    ext_sda_low = 1'b1;
    expect_code(8'h38, "R10");
    wr(1'b1, 8'hA0); wr(1'b0, EN); wait_flag("R10");
    check(!scl_oe && !sda_oe, "R10", "bus released after loss", {scl_oe, sda_oe}, 0);
    ext_sda_low = 1'b0;
    repeat (10) @(negedge clk);
    wr(1'b0, EN);

    // R3 busy bus defers START
    ext_sda_low = 1'b1;
    repeat (10) @(negedge clk);
    expect_code(8'h08, "R3");
    wr(1'b0, EN | STA);
    repeat (400) @(negedge clk);
    check(!ctrl_q[4] && !scl_oe && !sda_oe, "R3", "waits while bus busy",
          {ctrl_q[4], scl_oe, sda_oe}, 0);
    ext_sda_low = 1'b0;
    wait_flag("R3");
    do_stop(8'h00);

    // R12 rate select 2
    expect_code(8'h08, "R2");
    wr(1'b0, EN | STA | 8'h02); wait_flag("R2");
    expect_code(8'h18, "R5");
    wr(1'b1, 8'hA0); wr(1'b0, EN | 8'h02);
    measure(4 * (BASE_DIV << 2), "R12");
    wait_flag("R5");
    do_stop(8'h02);

    // R13 disabled controller ignores start
    wr(1'b0, STA);
    repeat (400) @(negedge clk);
    check(!ctrl_q[4] && !scl_oe && !sda_oe && status_q == 8'hF8, "R13",
          "no activity while disabled", {ctrl_q[4], scl_oe, sda_oe}, 0);
    wr(1'b0, 8'h00);
    check(exp_q.size() == 0, "R4", "all expected events seen", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule